// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one read or write burst in a four-bank synchronous DRAM model or controller. A column command loads a start column together with the burst configuration: a length code, a wrap order and the device data width. From the next clock on, the block presents one column address per cycle. A fixed-length burst ends after its final beat. A full-page burst keeps wrapping around the page until a terminate strobe stops it.

The column width follows the organisation. A x4 part has a 10-bit column, x8 has 9 bits and x16 has 8 bits. The column bits that a narrower organisation does not use are always driven to zero. A new start may arrive on any clock, including in the middle of a burst or on the same edge as a terminate. All inputs are sampled on the rising edge.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first start, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i sampled at an edge makes valid_o 1 after that edge, with col_o equal to start_col_i. Column bits above the page are forced to zero. The page is selected by width_sel_i: 0 gives x4 with 10 bits, 1 gives x8 with 9 bits, and 2 or 3 give x16 with 8 bits.
- R3: bl_code_i selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 behave as length 1. A fixed-length burst keeps valid_o high for exactly its length in cycles. last_o is 1 only on the final beat, and valid_o is 0 on the cycle that follows the final beat.
- R4: With wrap_il_i = 0 (sequential), beat n has its low log2(length) bits equal to (start + n) modulo the length. The upper bits equal those of the start column.
- R5: With wrap_il_i = 1 (interleaved), beat n equals the start column with its low log2(length) bits XORed with n.
- R6: A full-page burst steps the whole column by 1 modulo the page size and ignores wrap_il_i. It never asserts last_o and continues until terminated or restarted.
- R7: A term_i sampled during a burst makes valid_o 0 after that edge. If start_i is sampled on the same edge, the start wins.
- R8: A start_i sampled during a burst discards the old burst on that edge. The next cycle shows beat 0 of the new burst.
- R9: A burst of length 1 presents only the start column, for one cycle, with last_o high.
- R10: Whenever valid_o is 1, the column bits outside the selected page are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command accepted; load a new burst |
| start_col_i | input | COL_W | Start column |
| bl_code_i | input | 3 | Burst length code |
| wrap_il_i | input | 1 | 1 selects interleaved order, 0 sequential |
| width_sel_i | input | 2 | Data width: 0 x4, 1 x8, 2/3 x16 |
| term_i | input | 1 | Burst terminate |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check that a start loads the masked start column and that last_o only appears inside a burst. They also check that a burst ends on the cycle after its last beat or after a terminate, that an unfinished burst keeps running, and that no out-of-page column bit is ever set. Which address each beat should carry is shown only by the bench's scenarios. These cover the sequential and interleaved orders for each length and the full-page wrap across the page boundary. They also cover the precedence of start over terminate and the restarts in mid-burst or on back-to-back cycles.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [1:0] {
    WID_X4   = 2'd0,
    WID_X8   = 2'd1,
    WID_X16  = 2'd2,
    WID_X16B = 2'd3
  } wid_e;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } bl_e;

  // page shift: how many top column bits the width leaves unused
  function automatic logic [1:0] page_shift(input logic [1:0] wsel);
    return (wsel == WID_X16B) ? 2'd2 : wsel;
  endfunction
endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_il_i,
  input  logic [1:0]       width_sel_i,
  output logic [COL_W-1:0] wrap_mask_o,
  output logic [COL_W-1:0] page_mask_o,
  output logic             full_o,
  output logic             il_o
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  always_comb begin
    page_mask_o = ALL_ONES >> page_shift(width_sel_i);
    full_o      = (bl_code_i == BL_PAGE);
    unique case (bl_code_i)
      BL_2:    wrap_mask_o = COL_W'(1);
      BL_4:    wrap_mask_o = COL_W'(3);
      BL_8:    wrap_mask_o = COL_W'(7);
      BL_PAGE: wrap_mask_o = page_mask_o;
      default: wrap_mask_o = '0;  // length 1, reserved codes too
    endcase
    il_o = wrap_il_i & ~full_o;  // full page only wraps sequentially
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] wrap_mask_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o
);
  logic             valid_q;
  logic [COL_W-1:0] beat_q;
  logic             at_end;

  assign at_end  = valid_q & ~full_i & (beat_q == wrap_mask_i);
  assign valid_o = valid_q;
  assign last_o  = at_end;
  assign beat_o  = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
    end else if (valid_q) begin
      if (term_i || at_end) valid_q <= 1'b0;
      else                  beat_q  <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] wrap_mask_i,
  input  logic [COL_W-1:0] page_mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] offs;

  always_comb begin
    offs  = il_i ? ((base_i ^ beat_i) & wrap_mask_i)
                 : ((base_i + beat_i) & wrap_mask_i);
    col_o = ((base_i & ~wrap_mask_i) | offs) & page_mask_i;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_il_i,
  input  logic [1:0]       width_sel_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] wrap_mask_d, page_mask_d;
  logic             full_d, il_d;

  logic [COL_W-1:0] base_q, wrap_mask_q, page_mask_q;
  logic             full_q, il_q;
  logic [COL_W-1:0] beat;

  burst_cfg_dec #(.COL_W(COL_W)) u_dec (
    .bl_code_i   (bl_code_i),
    .wrap_il_i   (wrap_il_i),
    .width_sel_i (width_sel_i),
    .wrap_mask_o (wrap_mask_d),
    .page_mask_o (page_mask_d),
    .full_o      (full_d),
    .il_o        (il_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      wrap_mask_q <= '0;
      page_mask_q <= '0;
      full_q      <= 1'b0;
      il_q        <= 1'b0;
    end else if (start_i) begin
      base_q      <= start_col_i & page_mask_d;
      wrap_mask_q <= wrap_mask_d;
      page_mask_q <= page_mask_d;
      full_q      <= full_d;
      il_q        <= il_d;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .term_i      (term_i),
    .full_i      (full_q),
    .wrap_mask_i (wrap_mask_q),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .beat_o      (beat)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_i      (base_q),
    .beat_i      (beat),
    .wrap_mask_i (wrap_mask_q),
    .page_mask_i (page_mask_q),
    .il_i        (il_q),
    .col_o       (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [1:0]       width_sel_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [COL_W-1:0] page_mask_q
);
  logic [COL_W-1:0] exp_start;
  always_comb begin
    unique case (width_sel_i)
      2'd0:    exp_start = start_col_i;
      2'd1:    exp_start = start_col_i & ({COL_W{1'b1}} >> 1);
      default: exp_start = start_col_i & ({COL_W{1'b1}} >> 2);
    endcase
  end

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(exp_start));

  a_r3_last_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r3_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  a_r7_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && term_i && !start_i) |=> !valid_o);

  a_r6_burst_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !term_i) |=> valid_o);

  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (col_o & ~page_mask_q) == '0);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .width_sel_i (width_sel_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .page_mask_q (page_mask_q)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic             wrap_il_i = 1'b0;
  logic [1:0]       width_sel_i = '0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_valid = 0, m_base = 0, m_n = 0, m_len = 1, m_il = 0, m_page = 1024;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .wrap_il_i(wrap_il_i), .width_sel_i(width_sel_i),
    .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int len_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;  // full page
      default: return 1;
    endcase
  endfunction

  function automatic int page_of(input int w);
    return (w >= 2) ? 256 : ((w == 1) ? 512 : 1024);
  endfunction

  function automatic int exp_col();
    if (m_len == 0) return (m_base + m_n) % m_page;
    if (m_il != 0)  return m_base ^ m_n;
    return (m_base / m_len) * m_len + ((m_base % m_len) + m_n) % m_len;
  endfunction

  task automatic model_edge();
    if (start_i) begin
      m_valid = 1; m_n = 0;
      m_page  = page_of(int'(width_sel_i));
      m_base  = int'(start_col_i) % m_page;
      m_len   = len_of(int'(bl_code_i));
      m_il    = int'(wrap_il_i);
    end else if (m_valid != 0) begin
      if (term_i) m_valid = 0;
      else if (m_len != 0 && m_n == m_len - 1) m_valid = 0;
      else m_n = (m_len == 0) ? (m_n + 1) % m_page : m_n + 1;
    end
  endtask

  task automatic compare(input string tag);
    int e_last, e_col;
    e_last = (m_valid != 0 && m_len != 0 && m_n == m_len - 1) ? 1 : 0;
    e_col  = exp_col();
    n_chk++;
    if (int'(valid_o) != m_valid || int'(last_o) != e_last ||
        (m_valid != 0 && int'(col_o) != e_col)) begin
      n_bad++;
      $display("FAIL %s: valid/last/col got %0d/%0d/%h exp %0d/%0d/%h",
               tag, valid_o, last_o, col_o, m_valid, e_last, e_col);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int col, input int code, input int il, input int w,
                     input int cycles, input string tag);
    start_i = 1'b1; start_col_i = COL_W'(col); bl_code_i = 3'(code);
    wrap_il_i = il[0]; width_sel_i = 2'(w);
    step(tag);
    start_i = 1'b0;
    repeat (cycles) step(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    compare("R1");
    n_chk++;
    if (col_o !== '0) begin
      n_bad++; $display("FAIL R1: col got %h exp 000", col_o);
    end
    rst_ni = 1'b1;
    step("R1");
    step("R1");

    run('h1F6, 2, 0, 0, 5,   "R4");   // seq BL4 wrap inside group
    run('h0D5, 3, 1, 0, 9,   "R5");   // interleaved BL8
    run('h2B3, 3, 0, 0, 9,   "R4");   // seq BL8
    run('h123, 0, 0, 0, 3,   "R9");   // length 1
    run('h0FF, 1, 1, 0, 3,   "R3");   // BL2 interleaved
    run('h045, 5, 0, 0, 3,   "R3");   // reserved code -> length 1
    run('h3FF, 2, 0, 1, 6,   "R2");   // x8 drops top bit
    run('h3FA, 3, 1, 3, 9,   "R10");  // x16 via code 3
    run('h3FE, 7, 1, 2, 300, "R6");   // full page x16 wraps past 0xFF

    term_i = 1'b1; step("R7"); term_i = 1'b0;
    repeat (2) step("R7");

    run('h010, 3, 0, 0, 2, "R7");
    term_i = 1'b1; step("R7"); term_i = 1'b0;
    repeat (2) step("R7");

    // start and terminate on the same edge
    run('h020, 2, 0, 0, 1, "R7");
    start_i = 1'b1; term_i = 1'b1; start_col_i = 'h031; bl_code_i = 3'd2;
    step("R7");
    start_i = 1'b0; term_i = 1'b0;
    repeat (5) step("R7");

    // restart in mid-burst
    run('h040, 3, 0, 0, 3, "R8");
    run('h055, 1, 1, 0, 4, "R8");

    // full page restarted by a fixed burst
    run('h100, 7, 0, 0, 20, "R8");
    run('h107, 3, 0, 0, 9,  "R8");

    // start on every clock
    for (int i = 0; i < 6; i++) begin
      start_i = 1'b1; start_col_i = COL_W'(37 * i + 3); bl_code_i = 3'(i % 4);
      wrap_il_i = i[0]; width_sel_i = 2'(i % 3);
      step("R8");
    end
    start_i = 1'b0;
    repeat (10) step("R8");

    finish_run();
  end
endmodule